// File: doc/BRIEF.md
# Memory ECC Error Logger

This block watches the outcome reports that an ECC decoder produces on a memory controller's read path. Each checked read arrives as a one-cycle strobe with a flag that says whether the fault was fixed (corrected) or could not be fixed (uncorrectable), together with the syndrome and the location of the access: page, offset within the page, row, channel and module slot. The block only observes. The read data goes to the requester whatever the outcome, and it never passes through here.

Two sets of saturating counters keep the error history. One set holds a corrected and an uncorrectable count for every module position (channel and slot). The other is indexed by slot number alone, so the same slot on different channels shares one counter. That second set suits unregistered memory, where the channel cannot be told apart. Counting runs whether or not logging is enabled. Logging of each class is enabled separately. A logged error captures an error record and raises a sticky interrupt. The capture follows a severity rule, so an uncorrectable record is not lost to a later corrected one. A free-running cycle counter measures the time since the last counter reset. Software reaches all of this through a flat 32-bit register port with combinational read data and single-cycle writes.

Top module: `ecc_err_log`

## Requirements
- R1: An event with `ev_valid`=1 increments the uncorrectable count when `ev_uncorr`=1 and the corrected count when `ev_uncorr`=0. Exactly one class is counted per event.
- R2: Module position index = `ev_chan`*3 + `ev_slot`, for 3 channels of 3 slots. The counts of index i are read at address 0x08+i, with the corrected count in bits [15:0] and the uncorrectable count in bits [31:16].
- R3: A slot-aliased counter pair is kept per slot and read at address 0x18+slot, in the same bit layout as R2. An event on slot k of any channel increments pair k.
- R4: Counting does not depend on the logging enables. A disabled class still counts, but it sets no status bit, raises no interrupt and captures no record.
- R5: Every counter saturates at all ones (15 with the bench width of 4 bits) and does not wrap.
- R6: Writing 1 to bit 0 of address 0x01 clears every counter and the cycle counter. In a cycle with both this command and an event, the clear wins and the event is not counted.
- R7: A logged event captures a record. Address 0x03 reads the type in bit 0 (1 = uncorrectable), the channel in [7:4], the slot in [11:8] and the row in [23:16]. The page reads at 0x04, the offset at 0x05 and the syndrome at 0x06.
- R8: While the record holds an uncorrectable error and the uncorrectable pending bit is set, a logged corrected error does not overwrite it. A logged uncorrectable error always overwrites the record. A logged corrected error overwrites it in every other case.
- R9: Address 0x02 holds pending bits: bit 0 corrected, bit 1 uncorrectable. A logged error sets its bit, and writing 1 clears a bit. A set in the same cycle as a clear wins. `irq` is high whenever any pending bit is set, and it stays high until the bits are cleared.
- R10: Address 0x07 reads a cycle counter that increments on every clock and restarts at 0 on the R6 command.
- R11: Address 0x00 holds the logging enables: bit 0 corrected, bit 1 uncorrectable. After reset the enables, the pending bits, `irq`, the record and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Decoder reports an error this cycle |
| ev_uncorr | input | 1 | 1 = uncorrectable, 0 = corrected |
| ev_syndrome | input | SYN_W (8) | Error syndrome |
| ev_page | input | PAGE_W (20) | Failing page |
| ev_offset | input | OFF_W (12) | Offset within the page |
| ev_row | input | ROW_W (3) | Failing row |
| ev_chan | input | CH_W (2) | Failing channel |
| ev_slot | input | SL_W (2) | Failing slot within the channel |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Sticky error interrupt |

## Verification
The checker assumes that `ev_chan` and `ev_slot` stay within the 3-by-3 array whenever `ev_valid` is high. It also assumes that software writes the pending register only to clear bits, so that a write alone never raises `irq`. The stimulus draws channels and slots with `$urandom_range` limited to 0 to 2. It mixes enable changes, status clears and counter-reset commands into the random event stream, and places some of them in the same cycle as an event. The checker watches the saturation of the slot-aliased counters, which a small counter width brings within reach.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

    typedef enum logic {
        ERR_CE = 1'b0,
        ERR_UE = 1'b1
    } err_kind_e;

    localparam int REG_AW = 5;
    localparam int REG_DW = 32;

    localparam logic [REG_AW-1:0] A_CTRL      = 5'h00;
    localparam logic [REG_AW-1:0] A_CMD       = 5'h01;
    localparam logic [REG_AW-1:0] A_STAT      = 5'h02;
    localparam logic [REG_AW-1:0] A_INFO      = 5'h03;
    localparam logic [REG_AW-1:0] A_PAGE      = 5'h04;
    localparam logic [REG_AW-1:0] A_OFFS      = 5'h05;
    localparam logic [REG_AW-1:0] A_SYND      = 5'h06;
    localparam logic [REG_AW-1:0] A_CYC       = 5'h07;
    localparam logic [REG_AW-1:0] A_DIMM_BASE = 5'h08;
    localparam logic [REG_AW-1:0] A_SLOT_BASE = 5'h18;

    // Both counts of one pair in one word: corrected low, uncorrectable high.
    function automatic logic [REG_DW-1:0] pack_pair(input logic [15:0] ce,
                                                    input logic [15:0] ue);
        return {ue, ce};
    endfunction

endpackage

// File: rtl/ecc_cnt_bank.sv
module ecc_cnt_bank #(
    parameter int N     = 9,
    parameter int IDX_W = 4,
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               inc_en,
    input  logic [IDX_W-1:0]   inc_idx,
    input  logic               inc_ue,
    output logic [N*CNT_W-1:0] ce_flat,
    output logic [N*CNT_W-1:0] ue_flat
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    for (genvar i = 0; i < N; i++) begin : g_pair
        logic [CNT_W-1:0] ce_q, ue_q;
        logic             hit;

        assign hit = inc_en && (inc_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                ce_q <= '0;
                ue_q <= '0;
            end else if (hit) begin
                if (inc_ue) begin
                    if (ue_q != TOP) ue_q <= ue_q + 1'b1;
                end else begin
                    if (ce_q != TOP) ce_q <= ce_q + 1'b1;
                end
            end
        end

        assign ce_flat[i*CNT_W +: CNT_W] = ce_q;
        assign ue_flat[i*CNT_W +: CNT_W] = ue_q;
    end
endmodule

// File: rtl/ecc_rec_capture.sv
module ecc_rec_capture #(
    parameter int PAGE_W = 20,
    parameter int OFF_W  = 12,
    parameter int SYN_W  = 8,
    parameter int ROW_W  = 3,
    parameter int CH_W   = 2,
    parameter int SL_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              log_ce,
    input  logic              log_ue,
    input  logic [SYN_W-1:0]  in_syn,
    input  logic [PAGE_W-1:0] in_page,
    input  logic [OFF_W-1:0]  in_off,
    input  logic [ROW_W-1:0]  in_row,
    input  logic [CH_W-1:0]   in_chan,
    input  logic [SL_W-1:0]   in_slot,
    input  logic [1:0]        pend_clr,
    output logic [1:0]        pend,
    output ecc_log_pkg::err_kind_e rec_kind,
    output logic [SYN_W-1:0]  rec_syn,
    output logic [PAGE_W-1:0] rec_page,
    output logic [OFF_W-1:0]  rec_off,
    output logic [ROW_W-1:0]  rec_row,
    output logic [CH_W-1:0]   rec_chan,
    output logic [SL_W-1:0]   rec_slot
);
    import ecc_log_pkg::*;

    logic ue_locked, take;

    assign ue_locked = (rec_kind == ERR_UE) && pend[1];
    assign take      = log_ue || (log_ce && !ue_locked);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else begin
            pend <= (pend & ~pend_clr) | {log_ue, log_ce};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_kind <= ERR_CE;
            rec_syn  <= '0;
            rec_page <= '0;
            rec_off  <= '0;
            rec_row  <= '0;
            rec_chan <= '0;
            rec_slot <= '0;
        end else if (take) begin
            rec_kind <= log_ue ? ERR_UE : ERR_CE;
            rec_syn  <= in_syn;
            rec_page <= in_page;
            rec_off  <= in_off;
            rec_row  <= in_row;
            rec_chan <= in_chan;
            rec_slot <= in_slot;
        end
    end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log #(
    parameter int NUM_CH   = 3,
    parameter int SLOTS    = 3,
    parameter int CNT_W    = 16,
    parameter int PAGE_W   = 20,
    parameter int OFF_W    = 12,
    parameter int SYN_W    = 8,
    parameter int ROW_W    = 3,
    parameter int CYC_W    = 32,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int SL_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  logic              ev_uncorr,
    input  logic [SYN_W-1:0]  ev_syndrome,
    input  logic [PAGE_W-1:0] ev_page,
    input  logic [OFF_W-1:0]  ev_offset,
    input  logic [ROW_W-1:0]  ev_row,
    input  logic [CH_W-1:0]   ev_chan,
    input  logic [SL_W-1:0]   ev_slot,
    input  logic              reg_wr,
    input  logic [4:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    import ecc_log_pkg::*;

    localparam int NUM_DIMM = NUM_CH * SLOTS;
    localparam int DIDX_W   = (NUM_DIMM > 1) ? $clog2(NUM_DIMM) : 1;

    // Software side decode
    logic wr_ctrl, cmd_clr;
    logic [1:0] pend_clr;
    assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
    assign cmd_clr  = reg_wr && (reg_addr == A_CMD) && reg_wdata[0];
    assign pend_clr = (reg_wr && (reg_addr == A_STAT)) ? reg_wdata[1:0] : 2'b00;

    logic unused_wdata;
    assign unused_wdata = ^reg_wdata[31:2];

    logic [1:0] log_en;   // bit0 corrected, bit1 uncorrectable
    always_ff @(posedge clk) begin
        if (rst)          log_en <= '0;
        else if (wr_ctrl) log_en <= reg_wdata[1:0];
    end

    // Time since the last counter reset
    logic [CYC_W-1:0] cyc_q;
    always_ff @(posedge clk) begin
        if (rst || cmd_clr) cyc_q <= '0;
        else                cyc_q <= cyc_q + 1'b1;
    end

    // Event location
    logic              loc_ok;
    logic [DIDX_W-1:0] dimm_idx;
    assign loc_ok   = (32'(ev_chan) < NUM_CH) && (32'(ev_slot) < SLOTS);
    assign dimm_idx = DIDX_W'(ev_chan) * DIDX_W'(SLOTS) + DIDX_W'(ev_slot);

    logic [NUM_DIMM*CNT_W-1:0] dimm_ce, dimm_ue;
    logic [SLOTS*CNT_W-1:0]    slot_ce, slot_ue;

    ecc_cnt_bank #(.N(NUM_DIMM), .IDX_W(DIDX_W), .CNT_W(CNT_W)) u_dimm_bank (
        .clk     (clk),
        .rst     (rst),
        .clr     (cmd_clr),
        .inc_en  (ev_valid && loc_ok),
        .inc_idx (dimm_idx),
        .inc_ue  (ev_uncorr),
        .ce_flat (dimm_ce),
        .ue_flat (dimm_ue)
    );

    ecc_cnt_bank #(.N(SLOTS), .IDX_W(SL_W), .CNT_W(CNT_W)) u_slot_bank (
        .clk     (clk),
        .rst     (rst),
        .clr     (cmd_clr),
        .inc_en  (ev_valid && loc_ok),
        .inc_idx (ev_slot),
        .inc_ue  (ev_uncorr),
        .ce_flat (slot_ce),
        .ue_flat (slot_ue)
    );

    // Record and pending status
    logic [1:0]        pend;
    err_kind_e         rec_kind;
    logic [SYN_W-1:0]  rec_syn;
    logic [PAGE_W-1:0] rec_page;
    logic [OFF_W-1:0]  rec_off;
    logic [ROW_W-1:0]  rec_row;
    logic [CH_W-1:0]   rec_chan;
    logic [SL_W-1:0]   rec_slot;
    logic              rec_ue;

    ecc_rec_capture #(
        .PAGE_W(PAGE_W), .OFF_W(OFF_W), .SYN_W(SYN_W),
        .ROW_W(ROW_W), .CH_W(CH_W), .SL_W(SL_W)
    ) u_rec (
        .clk      (clk),
        .rst      (rst),
        .log_ce   (ev_valid && !ev_uncorr && log_en[0]),
        .log_ue   (ev_valid &&  ev_uncorr && log_en[1]),
        .in_syn   (ev_syndrome),
        .in_page  (ev_page),
        .in_off   (ev_offset),
        .in_row   (ev_row),
        .in_chan  (ev_chan),
        .in_slot  (ev_slot),
        .pend_clr (pend_clr),
        .pend     (pend),
        .rec_kind (rec_kind),
        .rec_syn  (rec_syn),
        .rec_page (rec_page),
        .rec_off  (rec_off),
        .rec_row  (rec_row),
        .rec_chan (rec_chan),
        .rec_slot (rec_slot)
    );

    assign rec_ue = (rec_kind == ERR_UE);
    assign irq    = |pend;

    // Read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: reg_rdata = 32'(log_en);
            A_STAT: reg_rdata = 32'(pend);
            A_INFO: reg_rdata = 32'(rec_ue) | (32'(rec_chan) << 4)
                              | (32'(rec_slot) << 8) | (32'(rec_row) << 16);
            A_PAGE: reg_rdata = 32'(rec_page);
            A_OFFS: reg_rdata = 32'(rec_off);
            A_SYND: reg_rdata = 32'(rec_syn);
            A_CYC:  reg_rdata = 32'(cyc_q);
            default: begin
                for (int i = 0; i < NUM_DIMM; i++) begin
                    if (reg_addr == A_DIMM_BASE + 5'(i))
                        reg_rdata = pack_pair(16'(dimm_ce[i*CNT_W +: CNT_W]),
                                              16'(dimm_ue[i*CNT_W +: CNT_W]));
                end
                for (int k = 0; k < SLOTS; k++) begin
                    if (reg_addr == A_SLOT_BASE + 5'(k))
                        reg_rdata = pack_pair(16'(slot_ce[k*CNT_W +: CNT_W]),
                                              16'(slot_ue[k*CNT_W +: CNT_W]));
                end
            end
        endcase
    end
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk #(
    parameter int SLOTS = 3,
    parameter int CNT_W = 16,
    parameter int CYC_W = 32
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   ev_valid,
    input logic                   ev_uncorr,
    input logic                   reg_wr,
    input logic [4:0]             reg_addr,
    input logic [31:0]            reg_wdata,
    input logic                   irq,
    input logic [1:0]             log_en,
    input logic                   rec_ue,
    input logic [1:0]             pend,
    input logic [CYC_W-1:0]       cyc_q,
    input logic [SLOTS*CNT_W-1:0] slot_ce,
    input logic [SLOTS*CNT_W-1:0] slot_ue
);
    import ecc_log_pkg::*;

    logic stat_wr, clr_cmd;
    assign stat_wr = reg_wr && (reg_addr == A_STAT);
    assign clr_cmd = reg_wr && (reg_addr == A_CMD) && reg_wdata[0];

    // R9
    irq_set_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_uncorr && log_en[1]) |=> irq);

    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !stat_wr) |=> irq);

    // R8
    ue_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (rec_ue && pend[1] && !stat_wr) |=> rec_ue);

    // R6
    cyc_clr_chk: assert property (@(posedge clk) disable iff (rst)
        clr_cmd |=> (cyc_q == '0));

    // R10
    cyc_run_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_cmd |=> (cyc_q == CYC_W'($past(cyc_q) + 1'b1)));

    // R11
    rst_state_chk: assert property (@(posedge clk)
        rst |=> (!irq && (cyc_q == '0) && (log_en == 2'b00)));

    for (genvar k = 0; k < SLOTS; k++) begin : g_sat
        // R5
        ce_sat_chk: assert property (@(posedge clk) disable iff (rst)
            ((slot_ce[k*CNT_W +: CNT_W] == {CNT_W{1'b1}}) && !clr_cmd)
            |=> (slot_ce[k*CNT_W +: CNT_W] == {CNT_W{1'b1}}));
        // R5
        ue_sat_chk: assert property (@(posedge clk) disable iff (rst)
            ((slot_ue[k*CNT_W +: CNT_W] == {CNT_W{1'b1}}) && !clr_cmd)
            |=> (slot_ue[k*CNT_W +: CNT_W] == {CNT_W{1'b1}}));
    end
endmodule

bind ecc_err_log ecc_err_log_chk #(
    .SLOTS(SLOTS), .CNT_W(CNT_W), .CYC_W(CYC_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ev_valid  (ev_valid),
    .ev_uncorr (ev_uncorr),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq       (irq),
    .log_en    (log_en),
    .rec_ue    (rec_ue),
    .pend      (pend),
    .cyc_q     (cyc_q),
    .slot_ce   (slot_ce),
    .slot_ue   (slot_ue)
);

// File: tb/ecc_err_log_test.sv
module ecc_err_log_test;
    localparam int CW = 4;
    localparam int MAXC = 15;

    logic        clk = 0;
    logic        rst = 1;
    logic        ev_valid = 0, ev_uncorr = 0;
    logic [7:0]  ev_syndrome = 0;
    logic [19:0] ev_page = 0;
    logic [11:0] ev_offset = 0;
    logic [2:0]  ev_row = 0;
    logic [1:0]  ev_chan = 0, ev_slot = 0;
    logic        reg_wr = 0;
    logic [4:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        irq;

    ecc_err_log #(.CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_uncorr(ev_uncorr),
        .ev_syndrome(ev_syndrome), .ev_page(ev_page), .ev_offset(ev_offset),
        .ev_row(ev_row), .ev_chan(ev_chan), .ev_slot(ev_slot),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    int checks = 0, errors = 0;

    // reference model
    int mce[9], mue[9], sce[3], sue[3];
    logic [1:0]  men = 0, mpend = 0;
    logic        r_ue = 0;
    logic [7:0]  r_syn = 0;
    logic [19:0] r_page = 0;
    logic [11:0] r_off = 0;
    logic [2:0]  r_row = 0;
    logic [1:0]  r_ch = 0, r_sl = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pair(input int c, input int u);
        return {16'(u), 16'(c)};
    endfunction

    function automatic logic [31:0] info_exp();
        return 32'(r_ue) | (32'(r_ch) << 4) | (32'(r_sl) << 8) | (32'(r_row) << 16);
    endfunction

    function automatic int satinc(input int v);
        return (v < MAXC) ? v + 1 : v;
    endfunction

    // One cycle with an optional event and an optional register write.
    task automatic step(input bit ev, input bit ue, input logic [1:0] ch, input logic [1:0] sl,
                        input logic [7:0] syn, input logic [19:0] pg, input logic [11:0] off,
                        input logic [2:0] row, input bit wr, input logic [4:0] a,
                        input logic [31:0] d);
        bit clr, lg_ce, lg_ue;
        @(negedge clk);
        ev_valid = ev; ev_uncorr = ue; ev_chan = ch; ev_slot = sl;
        ev_syndrome = syn; ev_page = pg; ev_offset = off; ev_row = row;
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        ev_valid = 0; reg_wr = 0;
        clr   = wr && (a == 5'h01) && d[0];
        lg_ce = ev && !ue && men[0];
        lg_ue = ev && ue && men[1];
        if (clr) begin
            foreach (mce[i]) begin mce[i] = 0; mue[i] = 0; end
            foreach (sce[i]) begin sce[i] = 0; sue[i] = 0; end
        end else if (ev) begin
            if (ue) begin
                mue[ch*3+sl] = satinc(mue[ch*3+sl]); sue[sl] = satinc(sue[sl]);
            end else begin
                mce[ch*3+sl] = satinc(mce[ch*3+sl]); sce[sl] = satinc(sce[sl]);
            end
        end
        if (lg_ue || (lg_ce && !(r_ue && mpend[1]))) begin
            r_ue = lg_ue; r_syn = syn; r_page = pg; r_off = off;
            r_row = row; r_ch = ch; r_sl = sl;
        end
        if (wr && a == 5'h02) mpend = mpend & ~d[1:0];
        mpend = mpend | {lg_ue, lg_ce};
        if (wr && a == 5'h00) men = d[1:0];
    endtask

    task automatic ev_only(input bit ue, input logic [1:0] ch, input logic [1:0] sl,
                           input logic [7:0] syn, input logic [19:0] pg,
                           input logic [11:0] off, input logic [2:0] row);
        step(1, ue, ch, sl, syn, pg, off, row, 0, 5'h00, 32'h0);
    endtask

    task automatic wr_only(input logic [4:0] a, input logic [31:0] d);
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, a, d);
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic check_counters(input string req);
        logic [31:0] v;
        for (int i = 0; i < 9; i++) begin
            rd(5'h08 + 5'(i), v); chk(req, v, pair(mce[i], mue[i]));
        end
        for (int k = 0; k < 3; k++) begin
            rd(5'h18 + 5'(k), v); chk(req, v, pair(sce[k], sue[k]));
        end
    endtask

    task automatic check_record(input string req);
        logic [31:0] v;
        rd(5'h03, v); chk(req, v, info_exp());
        rd(5'h04, v); chk(req, v, 32'(r_page));
        rd(5'h05, v); chk(req, v, 32'(r_off));
        rd(5'h06, v); chk(req, v, 32'(r_syn));
        rd(5'h02, v); chk(req, v, 32'(mpend));
        chk(req, 32'(irq), 32'(|mpend));
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        foreach (mce[i]) begin mce[i] = 0; mue[i] = 0; end
        foreach (sce[i]) begin sce[i] = 0; sue[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;

        // R11 reset state
        chk("R11 irq", 32'(irq), 0);
        rd(5'h00, v); chk("R11 ctrl", v, 0);
        check_record("R11 record");
        check_counters("R11 counters");

        // R4: logging disabled, counting continues, nothing logged
        ev_only(0, 2'd1, 2'd2, 8'h11, 20'h1, 12'h2, 3'd1);
        ev_only(1, 2'd2, 2'd0, 8'h22, 20'h3, 12'h4, 3'd2);
        check_counters("R4 count while disabled");
        check_record("R4 no log while disabled");

        // R1/R2/R3 mapping and aliasing
        ev_only(0, 2'd0, 2'd1, 8'h0, 20'h0, 12'h0, 3'd0);
        ev_only(0, 2'd2, 2'd1, 8'h0, 20'h0, 12'h0, 3'd0);
        ev_only(1, 2'd1, 2'd1, 8'h0, 20'h0, 12'h0, 3'd0);
        rd(5'h08 + 5'd7, v); chk("R2 dimm7", v, pair(1, 0));
        rd(5'h18 + 5'd1, v); chk("R3 slot1 alias", v, pair(2, 1));
        rd(5'h08 + 5'd6, v); chk("R1 ue class", v, pair(0, 1));
        check_counters("R1 R2 R3");

        // R7 capture with both enables
        wr_only(5'h00, 32'h3);
        rd(5'h00, v); chk("R11 ctrl write", v, 32'h3);
        ev_only(0, 2'd2, 2'd1, 8'hA5, 20'hBEEF1, 12'h7C4, 3'd5);
        check_record("R7 corrected capture");

        // R8 severity
        ev_only(1, 2'd0, 2'd2, 8'h3C, 20'h12345, 12'h0F0, 3'd6);
        check_record("R8 ue replaces ce");
        ev_only(0, 2'd1, 2'd0, 8'h77, 20'h54321, 12'h111, 3'd2);
        check_record("R8 ce blocked by ue");
        rd(5'h03, v); chk("R8 type stays ue", v & 32'h1, 32'h1);
        wr_only(5'h02, 32'h2);
        chk("R9 irq after partial clear", 32'(irq), 1);
        ev_only(0, 2'd1, 2'd0, 8'h78, 20'h54322, 12'h112, 3'd3);
        check_record("R8 ce after ue cleared");

        // R9 sticky and clear, set wins over clear
        repeat (4) @(negedge clk);
        chk("R9 sticky", 32'(irq), 1);
        wr_only(5'h02, 32'h3);
        chk("R9 cleared", 32'(irq), 0);
        step(1, 1, 2'd2, 2'd2, 8'h9, 20'h9, 12'h9, 3'd1, 1, 5'h02, 32'h3);
        check_record("R9 set wins over clear");

        // R5 saturation
        for (int n = 0; n < 20; n++) ev_only(0, 2'd1, 2'd1, 8'h1, 20'h1, 12'h1, 3'd1);
        rd(5'h08 + 5'd4, v); chk("R5 saturate dimm", v & 32'hFFFF, MAXC);
        rd(5'h18 + 5'd1, v); chk("R5 saturate slot", v & 32'hFFFF, MAXC);
        check_counters("R5 counters");

        // R6 clear wins over simultaneous event
        step(1, 0, 2'd0, 2'd0, 8'h1, 20'h1, 12'h1, 3'd1, 1, 5'h01, 32'h1);
        check_counters("R6 clear all");
        rd(5'h08, v); chk("R6 event during clear dropped", v, 0);

        // R10 cycle counter
        wr_only(5'h01, 32'h1);
        repeat (6) @(negedge clk);
        rd(5'h07, v); chk("R10 cycles since clear", v, 7);
        rd(5'h07, v); chk("R10 cycles advance", v, 8);

        // Random mix
        void'($urandom(32'h5EED1234));
        for (int n = 0; n < 600; n++) begin
            int sel;
            sel = $urandom_range(0, 19);
            if (sel == 0)
                wr_only(5'h00, 32'($urandom_range(0, 3)));
            else if (sel == 1)
                wr_only(5'h02, 32'($urandom_range(1, 3)));
            else if (sel == 2 && n % 7 == 0)
                step(1, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 2)),
                     2'($urandom_range(0, 2)), 8'($urandom), 20'($urandom),
                     12'($urandom), 3'($urandom), 1, 5'h01, 32'h1);
            else if (sel == 3)
                step(1, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 2)),
                     2'($urandom_range(0, 2)), 8'($urandom), 20'($urandom),
                     12'($urandom), 3'($urandom), 1, 5'h02, 32'($urandom_range(1, 3)));
            else
                ev_only(1'($urandom_range(0, 1)), 2'($urandom_range(0, 2)),
                        2'($urandom_range(0, 2)), 8'($urandom), 20'($urandom),
                        12'($urandom), 3'($urandom));
            if (n % 25 == 0) check_record("R7 R8 R9 random record");
            if (n % 100 == 99) check_counters("R1 R3 R4 R5 random counters");
        end
        check_record("R7 R8 final record");
        check_counters("R2 R6 final counters");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule